// File: doc/BRIEF.md
# Two-Bank Indexed NVRAM Port

This block puts an index/data port front end on the byte storage of a real-time-clock-plus-NVRAM macro. A host reaches every byte through four port offsets. The low pair selects and moves bytes below address 128. That range holds the clock and control registers and then the first storage bank. The high pair selects and moves bytes 128 to 255 in the second bank. A write to an index offset latches the byte address. A read or write on the matching data offset then acts on that byte.

The low fourteen addresses (0 to 13) and three extension addresses (day alarm, month alarm, century) belong to the clock logic. Data accesses that hit them go out on a single-cycle clock-register interface and are never stored locally. Every other address is held in an internal byte array that starts at address 14. The size of the address space is a parameter of 64, 128 or 256 bytes. The second bank is backed only in the 256-byte build. Read data is registered and appears one cycle after the request, together with a one-cycle valid strobe.

Top module: `nvram_index_port`

## Requirements
- R1: A write on port offset 0 latches the low-bank index from bits 6:0 of the write data. Bit 7 is ignored, so writing 0x80|n selects address n.
- R2: A data access on port offset 1 reads or writes the stored byte at the low-bank index, for any address from 14 up to the configured space that is not a clock register.
- R3: A write on port offset 2 latches the high-bank index. A data access on port offset 3 acts on address 128 plus bits 6:0 of that index, and it never reaches the clock-register interface.
- R4: A low-bank data access to addresses 0 to 13 raises clk_req_o in the same cycle, with clk_addr_o set to the address, clk_we_o set to the direction and clk_wdata_o set to the write data. A read returns clk_rdata_i as sampled in that cycle.
- R5: The day-alarm, month-alarm and century addresses (defaults 0x3D, 0x3E, 0x32) are forwarded to the clock interface exactly as in R4, and they take no storage.
- R6: A data access to an address with no backing returns 0xFF and discards any write. In the 64-byte build this covers low-bank addresses 64 to 127. In every build below 256 bytes it covers the whole high bank.
- R7: An index register keeps its value across data accesses, so repeated data accesses hit the same byte.
- R8: rvalid_o is high for exactly the one cycle after a data-port read and is low after every other cycle. rdata_o holds its value until the next data read.
- R9: After reset both indexes are 0, rvalid_o and rdata_o are 0 and clk_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Port access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| port_i | input | 2 | Port offset: 0 low index, 1 low data, 2 high index, 3 high data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a data read |
| clk_req_o | output | 1 | Access forwarded to the clock registers |
| clk_we_o | output | 1 | Forwarded access is a write |
| clk_addr_o | output | 7 | Forwarded clock-register address |
| clk_wdata_o | output | 8 | Forwarded write data |
| clk_rdata_i | input | 8 | Clock-register read data, same cycle |

## Verification
A 256-byte build and a 64-byte build share one stimulus stream. Every address from 0 to 255 is written with a value computed from the address and then read back. This separates stored bytes, forwarded clock registers (the bench models them as address XOR 0x5A) and unbacked holes that must read 0xFF. Index writes with bit 7 set, and high-bank indexes with bit 7 clear, show whether address bits are dropped or leak into the wrong bank. Back-to-back data accesses without a new index show whether the index holds its value. Reads of an index offset show whether a valid strobe appears where none is due.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    PORT_IDX_LO = 2'd0,
    PORT_DAT_LO = 2'd1,
    PORT_IDX_HI = 2'd2,
    PORT_DAT_HI = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_STORE = 2'd1,
    TGT_CLOCK = 2'd2
  } tgt_e;

  // addresses below this belong to the clock core
  localparam int unsigned CLK_REG_COUNT = 14;
endpackage

// File: rtl/nvp_index_regs.sv
module nvp_index_regs #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_lo_o,
  output logic [IDX_W-1:0] idx_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_lo_o <= '0;
      idx_hi_o <= '0;
    end else begin
      if (wr_lo_i) idx_lo_o <= wdata_i[IDX_W-1:0];
      if (wr_hi_i) idx_hi_o <= wdata_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/nvp_addr_decode.sv
module nvp_addr_decode
  import nvp_pkg::*;
#(
  parameter int unsigned SPACE_BYTES  = 256,
  parameter logic [7:0]  DAY_ALM_ADDR = 8'h3D,
  parameter logic [7:0]  MON_ALM_ADDR = 8'h3E,
  parameter logic [7:0]  CENTURY_ADDR = 8'h32,
  parameter int unsigned STORE_AW     = 8
) (
  input  logic                bank_hi_i,
  input  logic [6:0]          idx_lo_i,
  input  logic [6:0]          idx_hi_i,
  output logic [7:0]          addr_o,
  output tgt_e                tgt_o,
  output logic [STORE_AW-1:0] store_idx_o
);
  localparam logic [8:0] SPACE_L = 9'(SPACE_BYTES);
  localparam logic [7:0] CLK_L   = 8'(CLK_REG_COUNT);

  logic hi_backed;
  generate
    if (SPACE_BYTES > 128) begin : g_hi_bank
      assign hi_backed = 1'b1;
    end else begin : g_no_hi_bank
      assign hi_backed = 1'b0;
    end
  endgenerate

  logic is_clk, is_ext, backed;
  logic [7:0] offs;

  always_comb begin
    addr_o = bank_hi_i ? {1'b1, idx_hi_i} : {1'b0, idx_lo_i};
    is_ext = (addr_o == DAY_ALM_ADDR) || (addr_o == MON_ALM_ADDR) ||
             (addr_o == CENTURY_ADDR);
    is_clk = !bank_hi_i && ((addr_o < CLK_L) || is_ext);
    backed = bank_hi_i ? hi_backed : ({1'b0, addr_o} < SPACE_L);
    offs   = addr_o - CLK_L;
    store_idx_o = offs[STORE_AW-1:0];
    if (is_clk)      tgt_o = TGT_CLOCK;
    else if (backed) tgt_o = TGT_STORE;
    else             tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
  parameter int unsigned DEPTH = 242,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvp_pkg::*;
#(
  parameter int unsigned SPACE_BYTES  = 256,
  parameter logic [7:0]  DAY_ALM_ADDR = 8'h3D,
  parameter logic [7:0]  MON_ALM_ADDR = 8'h3E,
  parameter logic [7:0]  CENTURY_ADDR = 8'h32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] port_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o,
  output logic       clk_req_o,
  output logic       clk_we_o,
  output logic [6:0] clk_addr_o,
  output logic [7:0] clk_wdata_o,
  input  logic [7:0] clk_rdata_i
);
  localparam int unsigned STORE_DEPTH = SPACE_BYTES - CLK_REG_COUNT;
  localparam int unsigned STORE_AW    = $clog2(STORE_DEPTH);

  logic [6:0] idx_lo, idx_hi;
  logic [7:0] addr;
  tgt_e       tgt;
  logic [STORE_AW-1:0] store_idx;
  logic [7:0] store_rdata, rd_next;
  logic       data_acc, rd_acc, store_we;

  assign data_acc = req_i && port_i[0];
  assign rd_acc   = data_acc && !we_i;
  assign store_we = data_acc && we_i && (tgt == TGT_STORE);

  nvp_index_regs #(.IDX_W(7)) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (req_i && we_i && (port_i == PORT_IDX_LO)),
    .wr_hi_i  (req_i && we_i && (port_i == PORT_IDX_HI)),
    .wdata_i  (wdata_i),
    .idx_lo_o (idx_lo),
    .idx_hi_o (idx_hi)
  );

  nvp_addr_decode #(
    .SPACE_BYTES  (SPACE_BYTES),
    .DAY_ALM_ADDR (DAY_ALM_ADDR),
    .MON_ALM_ADDR (MON_ALM_ADDR),
    .CENTURY_ADDR (CENTURY_ADDR),
    .STORE_AW     (STORE_AW)
  ) u_dec (
    .bank_hi_i   (port_i[1]),
    .idx_lo_i    (idx_lo),
    .idx_hi_i    (idx_hi),
    .addr_o      (addr),
    .tgt_o       (tgt),
    .store_idx_o (store_idx)
  );

  nvp_store #(.DEPTH(STORE_DEPTH), .AW(STORE_AW)) u_store (
    .clk_i   (clk_i),
    .we_i    (store_we),
    .idx_i   (store_idx),
    .wdata_i (wdata_i),
    .rdata_o (store_rdata)
  );

  assign clk_req_o   = data_acc && (tgt == TGT_CLOCK);
  assign clk_we_o    = clk_req_o && we_i;
  assign clk_addr_o  = addr[6:0];
  assign clk_wdata_o = wdata_i;

  always_comb begin
    unique case (tgt)
      TGT_CLOCK: rd_next = clk_rdata_i;
      TGT_STORE: rd_next = store_rdata;
      default:   rd_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= 8'h00;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_acc;
      if (rd_acc) rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/nvram_index_port_chk.sv
module nvram_index_port_chk #(
  parameter logic [7:0] DAY_ALM_ADDR = 8'h3D,
  parameter logic [7:0] MON_ALM_ADDR = 8'h3E,
  parameter logic [7:0] CENTURY_ADDR = 8'h32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] port_i,
  input logic       rvalid_o,
  input logic       clk_req_o,
  input logic [6:0] clk_addr_o,
  input logic [6:0] idx_lo,
  input logic [6:0] idx_hi
);
  AST_CLK_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_req_o |-> ((clk_addr_o < 7'd14) || ({1'b0, clk_addr_o} == DAY_ALM_ADDR) ||
                   ({1'b0, clk_addr_o} == MON_ALM_ADDR) ||
                   ({1'b0, clk_addr_o} == CENTURY_ADDR))); // R4

  AST_CLK_LOW_BANK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_req_o |-> (req_i && port_i == 2'd1)); // R3

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && port_i[0]) |=> rvalid_o); // R8

  AST_RVALID_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i && port_i[0]) |=> !rvalid_o); // R8

  AST_INDEX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && !port_i[0]) |=> ($stable(idx_lo) && $stable(idx_hi))); // R7
endmodule

bind nvram_index_port nvram_index_port_chk #(
  .DAY_ALM_ADDR (DAY_ALM_ADDR),
  .MON_ALM_ADDR (MON_ALM_ADDR),
  .CENTURY_ADDR (CENTURY_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .port_i     (port_i),
  .rvalid_o   (rvalid_o),
  .clk_req_o  (clk_req_o),
  .clk_addr_o (clk_addr_o),
  .idx_lo     (idx_lo),
  .idx_hi     (idx_hi)
);

// File: tb/nvram_index_port_tb.sv
module nvram_index_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] port = 2'd0;
  logic [7:0] wdata = 8'h00;

  logic [7:0] rd_b, rd_s, cw_b, cw_s, cr_b, cr_s;
  logic       rv_b, rv_s, cq_b, cq_s, cwe_b, cwe_s;
  logic [6:0] ca_b, ca_s;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  assign cr_b = {1'b0, ca_b} ^ 8'h5A;
  assign cr_s = {1'b0, ca_s} ^ 8'h5A;

  nvram_index_port #(.SPACE_BYTES(256)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .port_i(port),
    .wdata_i(wdata), .rdata_o(rd_b), .rvalid_o(rv_b), .clk_req_o(cq_b),
    .clk_we_o(cwe_b), .clk_addr_o(ca_b), .clk_wdata_o(cw_b), .clk_rdata_i(cr_b)
  );

  nvram_index_port #(.SPACE_BYTES(64)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .port_i(port),
    .wdata_i(wdata), .rdata_o(rd_s), .rvalid_o(rv_s), .clk_req_o(cq_s),
    .clk_we_o(cwe_s), .clk_addr_o(ca_s), .clk_wdata_o(cw_s), .clk_rdata_i(cr_s)
  );

  function automatic logic is_clk(input logic [7:0] a);
    return (a < 8'd14) || (a == 8'h3D) || (a == 8'h3E) || (a == 8'h32);
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  function automatic logic [7:0] exp_val(input logic [7:0] a, input int space);
    if (is_clk(a)) return a ^ 8'h5A;
    if (a < space) return pat(a);
    return 8'hFF;
  endfunction

  task automatic check(input logic ok, input string r, input logic [7:0] act,
                       input logic [7:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual %02h expected %02h", r, act, expv);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; port = p; wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_index(input logic [7:0] a);
    bus(1'b1, a[7] ? 2'd2 : 2'd0, a);
    idle();
  endtask

  task automatic wr_data(input logic [7:0] a, input logic [7:0] d);
    logic fwd;
    fwd = !a[7] && is_clk(a);
    bus(1'b1, a[7] ? 2'd3 : 2'd1, d);
    #1;
    check(cq_b == fwd, fwd ? "R4/R5 fwd" : "R2/R3 no fwd", {7'd0, cq_b}, {7'd0, fwd});
    if (fwd)
      check(cwe_b && ca_b == a[6:0] && cw_b == d, "R4 fwd fields", {1'b0, ca_b}, a);
    idle();
  endtask

  task automatic rd_data(input logic [1:0] p, output logic [7:0] b, output logic [7:0] s);
    bus(1'b0, p, 8'h00);
    idle();
    check(rv_b && rv_s, "R8 rvalid", {6'd0, rv_b, rv_s}, 8'h03);
    b = rd_b;
    s = rd_s;
  endtask

  initial begin
    logic [7:0] b, s;
    repeat (3) @(negedge clk);
    check(rd_b == 8'h00 && !rv_b && !cq_b, "R9 reset", rd_b, 8'h00);
    check(rd_s == 8'h00 && !rv_s && !cq_s, "R9 reset small", rd_s, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // before any index write, index 0 is the seconds register
    rd_data(2'd1, b, s);
    check(b == 8'h5A && s == 8'h5A, "R9 index zero", b, 8'h5A);

    for (int i = 0; i < 256; i++) begin
      set_index(8'(i));
      wr_data(8'(i), pat(8'(i)));
    end
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a;
      a = 8'(i);
      set_index(a);
      rd_data(a[7] ? 2'd3 : 2'd1, b, s);
      check(b == exp_val(a, 256), a[7] ? "R3 hi bank" : (is_clk(a) ? "R4/R5 clock" : "R2 store"),
            b, exp_val(a, 256));
      check(s == exp_val(a, 64), (a >= 8'd64 && !is_clk(a)) ? "R6 unbacked" : "R2/R4 small",
            s, exp_val(a, 64));
    end

    // R1: bit 7 of a low index write is dropped
    bus(1'b1, 2'd0, 8'h80 | 8'd20); idle();
    rd_data(2'd1, b, s);
    check(b == pat(8'd20), "R1 bit7 ignored", b, pat(8'd20));

    // R3: high index with bit 7 clear still maps to 128+n
    bus(1'b1, 2'd2, 8'd5); idle();
    rd_data(2'd3, b, s);
    check(b == pat(8'd133), "R3 hi index", b, pat(8'd133));
    check(s == 8'hFF, "R6 hi absent", s, 8'hFF);

    // R7: repeated accesses on one index
    set_index(8'd40);
    wr_data(8'd40, 8'hC3);
    rd_data(2'd1, b, s);
    check(b == 8'hC3 && s == 8'hC3, "R7 same byte", b, 8'hC3);
    rd_data(2'd1, b, s);
    check(b == 8'hC3, "R7 reread", b, 8'hC3);

    // R6: write into unbacked low range in small build is discarded
    set_index(8'd100);
    wr_data(8'd100, 8'h11);
    rd_data(2'd1, b, s);
    check(s == 8'hFF, "R6 write discarded", s, 8'hFF);
    check(b == 8'h11, "R2 high low-bank", b, 8'h11);

    // R8: no valid on index read, data held
    bus(1'b0, 2'd0, 8'h00); idle();
    check(!rv_b && !rv_s, "R8 index read", {6'd0, rv_b, rv_s}, 8'h00);
    check(rd_b == 8'h11, "R8 rdata held", rd_b, 8'h11);
    @(negedge clk);
    check(!rv_b, "R8 one cycle", {7'd0, rv_b}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog actual 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule